// File: doc/BRIEF.md
# Host-Side Mode Controller with Walking-Zero Self-Test

This block sits between a receive data path and the host-side pins of an interface chip. A 3-bit mode word selects what the host pins carry. In normal operation the 36-bit word (32 data bits and 4 parity bits), the parity-error flag and a 3-bit select word pass straight through. In the board-test mode an internal generator replaces them. It walks a single zero across all 36 bus bits, raises the parity-error flag while the zero is in the parity field, and steps the select lines through every value, so board wiring and external registers can be checked without a live link.

The mode code 000 is the master clear. Power-up software holds it to zero every internal counter and state machine. Mode codes that are not defined drive the host pins to zero and keep the generator stopped. Outputs follow `mode_i` without a register stage. Only the pattern position and the select count are stored.

Top module: `mode_ctrl`

## Requirements
- R1: While `mode_i` is 000 (bit 2 is the most significant bit), all outputs are zero and the generator counters are cleared, so the next test run starts at bit 0 with select value 0.
- R2: While `mode_i` is 101, `host_data_o`, `host_perr_o` and `sel_o` equal `norm_data_i`, `norm_perr_i` and `norm_sel_i` in the same cycle.
- R3: While `mode_i` is 100, `host_data_o` has exactly one bit at 0. In the first cycle of the mode that bit is bit 0.
- R4: In mode 100 the zero moves up one bit position per clock. After bit 35 it wraps to bit 0.
- R5: In mode 100, `sel_o` starts at 0 and increments by one each time the zero wraps from bit 35 to bit 0. It visits all eight values and wraps from 7 to 0.
- R6: In mode 100, `host_perr_o` is 1 exactly when the zero lies in the parity field, bits 35 down to 32.
- R7: For mode values 001, 010, 011, 110 and 111, all outputs are zero and the generator is held at its start. Any mode other than 100 restarts the next test run at bit 0 with select value 0.
- R8: Asserting `rst_ni` low asynchronously clears the generator: in mode 100 the zero returns to bit 0 and `sel_o` to 0 without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Mode select: 000 clear, 100 test, 101 normal |
| norm_data_i | input | 36 | Normal-path word, parity in bits 35:32 |
| norm_perr_i | input | 1 | Normal-path parity-error flag |
| norm_sel_i | input | 3 | Normal-path select value |
| host_data_o | output | 36 | Host-side data and parity bus |
| host_perr_o | output | 1 | Host-side parity-error flag |
| sel_o | output | 3 | Host-side select lines |

## Verification
The bench holds the test mode for more than eight full passes. This covers the bit 35 to bit 0 wrap, where an off-by-one counter would skip a bit or show two zeros, and the select wrap from 7 to 0, where a wrong carry would stall or jump the select lines. It watches `host_perr_o` at the boundary between bits 31 and 32, where a misplaced compare would flag the wrong bits. It leaves test mode through clear, normal and each undefined code and then re-enters. A generator that is not cleared would resume mid-pattern, and a decode that treats undefined codes as normal would leak the pass-through data. It also pulses reset in the middle of a pass to catch a reset that only takes effect on a clock edge.

// File: rtl/mode_ctrl_pkg.sv
package mode_ctrl_pkg;
  typedef enum logic [2:0] {
    MODE_CLEAR = 3'b000,
    MODE_TEST  = 3'b100,
    MODE_NORM  = 3'b101
  } mode_e;

  typedef enum logic [1:0] {
    SRC_IDLE,
    SRC_NORM,
    SRC_TEST
  } src_e;
endpackage

// File: rtl/mode_decode.sv
module mode_decode
  import mode_ctrl_pkg::*;
(
  input  logic [2:0] mode_i,
  output src_e       src_o,
  output logic       run_o
);
  always_comb begin
    unique case (mode_i)
      MODE_TEST: src_o = SRC_TEST;
      MODE_NORM: src_o = SRC_NORM;
      default:   src_o = SRC_IDLE;
    endcase
  end

  assign run_o = (src_o == SRC_TEST);
endmodule

// File: rtl/walk_gen.sv
module walk_gen #(
  parameter int BUS_W = 36,
  parameter int SEL_W = 3,
  localparam int POS_W = $clog2(BUS_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  output logic [POS_W-1:0] pos_o,
  output logic [SEL_W-1:0] sel_o
);
  localparam logic [POS_W-1:0] LAST = POS_W'(BUS_W - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_o <= '0;
      sel_o <= '0;
    end else if (!run_i) begin
      pos_o <= '0;
      sel_o <= '0;
    end else if (pos_o == LAST) begin
      pos_o <= '0;
      sel_o <= sel_o + 1'b1;
    end else begin
      pos_o <= pos_o + 1'b1;
    end
  end

  assert_pos_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_o <= LAST);
  assert_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && pos_o != LAST) |=> (pos_o == $past(pos_o) + 1'b1) && $stable(sel_o));
  assert_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && pos_o == LAST) |=> (pos_o == '0) && (sel_o == $past(sel_o) + 1'b1));
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (pos_o == '0) && (sel_o == '0));
endmodule

// File: rtl/out_mux.sv
module out_mux
  import mode_ctrl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PAR_W  = 4,
  parameter int SEL_W  = 3,
  localparam int BUS_W = DATA_W + PAR_W,
  localparam int POS_W = $clog2(BUS_W)
) (
  input  src_e             src_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic [SEL_W-1:0] cnt_i,
  input  logic [BUS_W-1:0] norm_data_i,
  input  logic             norm_perr_i,
  input  logic [SEL_W-1:0] norm_sel_i,
  output logic [BUS_W-1:0] data_o,
  output logic             perr_o,
  output logic [SEL_W-1:0] sel_o
);
  logic [BUS_W-1:0] walk_vec;

  for (genvar i = 0; i < BUS_W; i++) begin : g_walk
    assign walk_vec[i] = (pos_i != POS_W'(i));
  end

  always_comb begin
    unique case (src_i)
      SRC_TEST: begin
        data_o = walk_vec;
        perr_o = (pos_i >= POS_W'(DATA_W));
        sel_o  = cnt_i;
      end
      SRC_NORM: begin
        data_o = norm_data_i;
        perr_o = norm_perr_i;
        sel_o  = norm_sel_i;
      end
      default: begin
        data_o = '0;
        perr_o = 1'b0;
        sel_o  = '0;
      end
    endcase
  end
endmodule

// File: rtl/mode_ctrl.sv
module mode_ctrl
  import mode_ctrl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PAR_W  = 4,
  parameter int SEL_W  = 3,
  localparam int BUS_W = DATA_W + PAR_W,
  localparam int POS_W = $clog2(BUS_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       mode_i,
  input  logic [BUS_W-1:0] norm_data_i,
  input  logic             norm_perr_i,
  input  logic [SEL_W-1:0] norm_sel_i,
  output logic [BUS_W-1:0] host_data_o,
  output logic             host_perr_o,
  output logic [SEL_W-1:0] sel_o
);
  src_e             src;
  logic             run;
  logic [POS_W-1:0] pos;
  logic [SEL_W-1:0] cnt;

  mode_decode u_dec (
    .mode_i (mode_i),
    .src_o  (src),
    .run_o  (run)
  );

  walk_gen #(.BUS_W(BUS_W), .SEL_W(SEL_W)) u_walk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .pos_o  (pos),
    .sel_o  (cnt)
  );

  out_mux #(.DATA_W(DATA_W), .PAR_W(PAR_W), .SEL_W(SEL_W)) u_mux (
    .src_i       (src),
    .pos_i       (pos),
    .cnt_i       (cnt),
    .norm_data_i (norm_data_i),
    .norm_perr_i (norm_perr_i),
    .norm_sel_i  (norm_sel_i),
    .data_o      (host_data_o),
    .perr_o      (host_perr_o),
    .sel_o       (sel_o)
  );

  assert_one_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'b100) |-> ($countones(~host_data_o) == 1));
  assert_perr_field_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'b100) |-> (host_perr_o == (host_data_o[BUS_W-1:DATA_W] != '1)));
  assert_clear_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'b000) |-> (host_data_o == '0 && !host_perr_o && sel_o == '0));
  assert_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'b101) |-> (host_data_o == norm_data_i && host_perr_o == norm_perr_i
                            && sel_o == norm_sel_i));
  assert_undef_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 3'b000 && mode_i != 3'b100 && mode_i != 3'b101)
      |-> (host_data_o == '0 && !host_perr_o && sel_o == '0));
endmodule

// File: tb/sim_mode_ctrl.sv
`timescale 1ns/1ps
module sim_mode_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode = 3'b000;
  logic [35:0] ndata = '0;
  logic        nperr = 1'b0;
  logic [2:0]  nsel = '0;
  logic [35:0] host_data;
  logic        host_perr;
  logic [2:0]  sel;

  int checks = 0;
  int errors = 0;
  int nt = 0;
  bit done = 0;

  typedef struct {
    logic [35:0] data;
    logic        perr;
    logic [2:0]  sel;
    string       tag;
  } exp_t;

  exp_t q[$];
  event ev;

  always #2.5 clk = ~clk;

  mode_ctrl u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .mode_i      (mode),
    .norm_data_i (ndata),
    .norm_perr_i (nperr),
    .norm_sel_i  (nsel),
    .host_data_o (host_data),
    .host_perr_o (host_perr),
    .sel_o       (sel)
  );

  task automatic drive(input logic r, input logic [2:0] m, input logic [35:0] d,
                       input logic pe, input logic [2:0] s, input string tag);
    exp_t e;
    int p;
    @(negedge clk);
    rst_n = r; mode = m; ndata = d; nperr = pe; nsel = s;
    if (!r) nt = 0;
    e.tag = tag;
    if (m == 3'b100) begin
      p = nt % 36;
      e.data = ~(36'b1 << p);
      e.perr = (p >= 32);
      e.sel  = 3'((nt / 36) % 8);
      if (r) nt++;
    end else if (m == 3'b101) begin
      e.data = d; e.perr = pe; e.sel = s;
      nt = 0;
    end else begin
      e.data = '0; e.perr = 1'b0; e.sel = '0;
      nt = 0;
    end
    q.push_back(e);
    ->ev;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(ev);
      #1;
      e = q.pop_front();
      checks++;
      if (host_data !== e.data || host_perr !== e.perr || sel !== e.sel) begin
        errors++;
        $display("FAIL %s: data=%h perr=%b sel=%0d expected data=%h perr=%b sel=%0d",
                 e.tag, host_data, host_perr, sel, e.data, e.perr, e.sel);
      end
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [2:0] undef [5] = '{3'b001, 3'b010, 3'b011, 3'b110, 3'b111};
    // reset state, R8 / R1
    for (int i = 0; i < 3; i++) drive(1'b0, 3'b000, '0, 1'b0, '0, "R8 reset idle");
    for (int i = 0; i < 3; i++) drive(1'b1, 3'b000, 36'hF_FFFF_FFFF, 1'b1, 3'd7, "R1 clear idle");
    // pass-through, R2
    drive(1'b1, 3'b101, 36'hA_5A5A_5A5A, 1'b1, 3'd5, "R2 pass");
    drive(1'b1, 3'b101, 36'h5_A5A5_A5A5, 1'b0, 3'd2, "R2 pass");
    drive(1'b1, 3'b101, 36'hF_0000_0001, 1'b1, 3'd7, "R2 pass");
    drive(1'b1, 3'b101, 36'h0_FFFF_FFFE, 1'b0, 3'd0, "R2 pass");
    // walking zero over more than eight passes, R3 R4 R5 R6
    for (int i = 0; i < 300; i++) drive(1'b1, 3'b100, 36'h1_2345_6789, 1'b1, 3'd6, "R3 R4 R5 R6 walk");
    // undefined codes, R7
    for (int k = 0; k < 5; k++)
      for (int i = 0; i < 2; i++) drive(1'b1, undef[k], 36'h3_3333_3333, 1'b1, 3'd3, "R7 undefined idle");
    for (int i = 0; i < 40; i++) drive(1'b1, 3'b100, '0, 1'b0, '0, "R7 restart after undefined");
    drive(1'b1, 3'b101, 36'h0_0000_00FF, 1'b1, 3'd1, "R7 normal between runs");
    for (int i = 0; i < 5; i++) drive(1'b1, 3'b100, '0, 1'b0, '0, "R7 restart after normal");
    // clear mid-run, R1
    for (int i = 0; i < 80; i++) drive(1'b1, 3'b100, '0, 1'b0, '0, "R4 walk");
    for (int i = 0; i < 2; i++) drive(1'b1, 3'b000, '0, 1'b0, '0, "R1 clear idle");
    for (int i = 0; i < 5; i++) drive(1'b1, 3'b100, '0, 1'b0, '0, "R1 restart after clear");
    // async reset mid-run, R8
    for (int i = 0; i < 50; i++) drive(1'b1, 3'b100, '0, 1'b0, '0, "R5 walk");
    for (int i = 0; i < 2; i++) drive(1'b0, 3'b100, '0, 1'b0, '0, "R8 async reset");
    for (int i = 0; i < 40; i++) drive(1'b1, 3'b100, '0, 1'b0, '0, "R8 resume from start");
    @(negedge clk);
    #2;
    done = 1;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d items left, expected 0", q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule